// File: doc/BRIEF.md
# Video Timing Reference Flag Extractor

This block sits on a 10-bit parallel video stream that carries one word per clock. It looks for timing reference sequences in the stream. Each sequence is four words: the all-ones word, two all-zeros words, and a flag word. From these sequences it produces horizontal blanking, vertical blanking and field outputs that line up word for word with a copy of the video. The video copy is delayed by the length of the sequence prefix.

The `hblank_sel` input picks one of two horizontal flag styles. The first style covers every word from the start of the end-of-active sequence through the last word of the start-of-active sequence. The second style follows the H bit carried in the decoded flag words.

A carrier-loss input from the front end marks the stream as invalid. While it is high, the video output is forced to the blanking level, all flags are held low and the lock indication is cleared. The lock output reports that end-of-active sequences arrive at a steady line spacing. It drops when that spacing changes, when no sequence arrives for a set number of clocks, or when the carrier is lost.

Top module: `vid_trs_flags`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `vid_out` equals BLANK_WORD (default 0x040) and `hblank`, `vblank`, `field` and `locked` are all 0.
- R2: A word sampled on `vid_in` at clock edge n appears on `vid_out` after edge n+3, unless it is muted. A timing sequence is the run 0x3FF, 0x000, 0x000, X, where bit 9 of X is 1. In X, bit 8 is the field bit, bit 7 is the vertical bit, and bit 6 is the horizontal bit (1 for end-of-active, 0 for start-of-active).
- R3: With `hblank_sel` = 0, `hblank` is 1 on every output word from the 0x3FF of an end-of-active sequence through the flag word of the following start-of-active sequence. It is 0 on all other words.
- R4: With `hblank_sel` = 1, `hblank` changes only on the output word that is a flag word, where it takes that word's horizontal bit. It holds until the next flag word. The mode input is applied on each edge, and both styles are tracked at all times.
- R5: `vblank` and `field` take the vertical and field bits of each flag word on the output word that carries it. They hold until the next flag word.
- R6: When `carrier_lost` is high at an edge, after that edge `vid_out` equals BLANK_WORD and `hblank`, `vblank` and `field` are 0. Decoding continues underneath, and the true values return on the first edge where the input is low again.
- R7: `locked` rises only on the edge that samples the flag word of an end-of-active sequence. It rises when the span since the previous end-of-active sequence equals the span measured one sequence earlier, both taken with the input valid.
- R8: `locked` is cleared on an edge where `carrier_lost` is high, when an end-of-active span differs from the one before, or TIMEOUT edges after the last sequence with no new sequence in between. Each of these also discards the stored span.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_in | input | W | Incoming video word |
| hblank_sel | input | 1 | Horizontal flag style: 0 full span, 1 from decoded H bit |
| carrier_lost | input | 1 | High when the incoming signal is invalid |
| vid_out | output | W | Delayed video, or blanking level while muted |
| hblank | output | 1 | Horizontal blanking flag aligned with `vid_out` |
| vblank | output | 1 | Vertical blanking flag aligned with `vid_out` |
| field | output | 1 | Field flag aligned with `vid_out` |
| locked | output | 1 | Stream carries sequences at a steady line spacing |

## Verification
The properties assume that timing sequences are at least four words apart. They also assume that no run of active or blanking words forms the 0x3FF, 0x000, 0x000 prefix, so an edge on a flag can be tied to the sequence word then on `vid_out`. The mode and carrier inputs are taken to be synchronous with the clock.

The stimulus stays within these limits. Active words are drawn from 0x080 upward, blanking words are the fixed blanking level, and lines are at least 26 words long. The mode and carrier inputs change only on the falling clock edge.

// File: rtl/vid_trs_pkg.sv
package vid_trs_pkg;
  // Number of words in a timing sequence (prefix plus flag word)
  localparam int TRS_LEN = 4;

  // Flags carried by the fourth word of a sequence
  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } trs_bits_t;
endpackage

// File: rtl/trs_detect.sv
module trs_detect
  import vid_trs_pkg::*;
#(
  parameter int           W     = 10,
  parameter logic [W-1:0] BLANK = 10'h040
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dly_word,
  output logic         hit,
  output trs_bits_t    bits
);
  localparam int DLY = TRS_LEN - 1;

  logic [W-1:0] stage [DLY];

  for (genvar i = 0; i < DLY; i++) begin : g_dly
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= BLANK;
        else     stage[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= BLANK;
        else     stage[i] <= stage[i-1];
      end
    end
  end

  // The oldest stage holds the prefix start when din is the flag word
  assign hit      = din[W-1] && (stage[0] == '0) && (stage[1] == '0) && (stage[DLY-1] == '1);
  assign bits     = '{f: din[W-2], v: din[W-3], h: din[W-4]};
  assign dly_word = stage[DLY-1];
endmodule

// File: rtl/blank_flags.sv
module blank_flags
  import vid_trs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      hit,
  input  trs_bits_t bits,
  input  logic      hmode,
  input  logic      mute,
  output logic      h_o,
  output logic      v_o,
  output logic      f_o
);
  localparam int LAT = TRS_LEN - 1;

  logic [LAT-1:0] hit_pipe;
  trs_bits_t      pend;
  logic           span_q, span_n, end_q, end_n;
  logic           trs_h_q, trs_h_n, v_q, v_n, f_q, f_n;

  always_comb begin
    span_n  = span_q;
    if (end_q)              span_n = 1'b0;   // word after last start-of-active word
    if (hit && bits.h)      span_n = 1'b1;   // prefix start of end-of-active
    end_n   = hit_pipe[LAT-1] && !pend.h;
    trs_h_n = hit_pipe[LAT-1] ? pend.h : trs_h_q;
    v_n     = hit_pipe[LAT-1] ? pend.v : v_q;
    f_n     = hit_pipe[LAT-1] ? pend.f : f_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_pipe <= '0;
      pend     <= '0;
      span_q   <= 1'b0;
      end_q    <= 1'b0;
      trs_h_q  <= 1'b0;
      v_q      <= 1'b0;
      f_q      <= 1'b0;
      h_o      <= 1'b0;
      v_o      <= 1'b0;
      f_o      <= 1'b0;
    end else begin
      hit_pipe <= {hit_pipe[LAT-2:0], hit};
      if (hit) pend <= bits;
      span_q   <= span_n;
      end_q    <= end_n;
      trs_h_q  <= trs_h_n;
      v_q      <= v_n;
      f_q      <= f_n;
      h_o      <= mute ? 1'b0 : (hmode ? trs_h_n : span_n);
      v_o      <= mute ? 1'b0 : v_n;
      f_o      <= mute ? 1'b0 : f_n;
    end
  end

  AST_MUTE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    $past(mute) |-> (!h_o && !v_o && !f_o)); // R6
endmodule

// File: rtl/trs_lock.sv
module trs_lock #(
  parameter int CNT_W   = 12,
  parameter int TIMEOUT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic is_eav,
  input  logic carrier_lost,
  output logic locked
);
  localparam int               IDLE_W  = $clog2(TIMEOUT + 1);
  localparam logic [IDLE_W-1:0] IDLE_END = IDLE_W'(TIMEOUT - 1);
  localparam logic [CNT_W-1:0]  GAP_MAX  = '1;

  logic [CNT_W-1:0]  eav_gap, span;
  logic [CNT_W-1:0]  gap_now;
  logic [IDLE_W-1:0] idle;
  logic              seen, have_span;

  assign gap_now = CNT_W'(eav_gap + 1'b1);

  always_ff @(posedge clk) begin
    if (rst || carrier_lost) begin
      eav_gap   <= '0;
      span      <= '0;
      idle      <= '0;
      seen      <= 1'b0;
      have_span <= 1'b0;
      locked    <= 1'b0;
    end else begin
      if (hit) begin
        idle <= '0;
      end else if (idle == IDLE_END) begin
        locked    <= 1'b0;
        seen      <= 1'b0;
        have_span <= 1'b0;
      end else begin
        idle <= idle + 1'b1;
      end
      if (hit && is_eav) begin
        eav_gap <= '0;
        seen    <= 1'b1;
        if (seen) begin
          span      <= gap_now;
          have_span <= 1'b1;
          locked    <= have_span && (gap_now == span);
        end
      end else if (eav_gap != GAP_MAX) begin
        eav_gap <= eav_gap + 1'b1;
      end
    end
  end

  AST_LOCK_ON_EAV: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(hit && is_eav)); // R7
  AST_LOCK_CARRIER: assert property (@(posedge clk) disable iff (rst)
    $past(carrier_lost) |-> !locked); // R8
endmodule

// File: rtl/vid_trs_flags.sv
module vid_trs_flags
  import vid_trs_pkg::*;
#(
  parameter int           W          = 10,
  parameter logic [W-1:0] BLANK_WORD = 10'h040,
  parameter int           CNT_W      = 12,
  parameter int           TIMEOUT    = 4096
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] vid_in,
  input  logic         hblank_sel,
  input  logic         carrier_lost,
  output logic [W-1:0] vid_out,
  output logic         hblank,
  output logic         vblank,
  output logic         field,
  output logic         locked
);
  logic [W-1:0] dly_word;
  logic         trs_hit;
  trs_bits_t    trs_bits;

  trs_detect #(.W(W), .BLANK(BLANK_WORD)) u_det (
    .clk(clk), .rst(rst), .din(vid_in),
    .dly_word(dly_word), .hit(trs_hit), .bits(trs_bits)
  );

  blank_flags u_flg (
    .clk(clk), .rst(rst), .hit(trs_hit), .bits(trs_bits),
    .hmode(hblank_sel), .mute(carrier_lost),
    .h_o(hblank), .v_o(vblank), .f_o(field)
  );

  trs_lock #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) u_lck (
    .clk(clk), .rst(rst), .hit(trs_hit), .is_eav(trs_bits.h),
    .carrier_lost(carrier_lost), .locked(locked)
  );

  always_ff @(posedge clk) begin
    if (rst || carrier_lost) vid_out <= BLANK_WORD;
    else                     vid_out <= dly_word;
  end

  AST_MUTE_BUS: assert property (@(posedge clk) disable iff (rst)
    $past(carrier_lost) |-> (vid_out == BLANK_WORD)); // R6
  AST_H_RISE_PREFIX: assert property (@(posedge clk) disable iff (rst)
    ($rose(hblank) && !$past(hblank_sel) && !$past(hblank_sel, 2)
     && !$past(carrier_lost) && !$past(carrier_lost, 2)) |-> (vid_out == '1)); // R3
  AST_H_AT_FLAG_WORD: assert property (@(posedge clk) disable iff (rst)
    ((hblank != $past(hblank)) && $past(hblank_sel) && $past(hblank_sel, 2)
     && !$past(carrier_lost) && !$past(carrier_lost, 2)) |-> vid_out[W-1]); // R4
  AST_V_AT_FLAG_WORD: assert property (@(posedge clk) disable iff (rst)
    ((vblank != $past(vblank)) && !$past(carrier_lost) && !$past(carrier_lost, 2))
    |-> vid_out[W-1]); // R5
endmodule

// File: tb/vid_trs_flags_bench.sv
module vid_trs_flags_bench;
  localparam int           TO      = 64;
  localparam logic [9:0]   BLANK   = 10'h040;
  localparam int           HB      = 6;
  localparam int           ACT     = 12;
  localparam int           GAP_MAX = 4095;

  typedef struct { logic [9:0] w; logic h0, h1, v, f; } exp_t;
  typedef struct { logic cl, hm, lk; } ctl_t;

  logic       clk = 1'b0, rst = 1'b1;
  logic [9:0] vid_in = BLANK;
  logic       hblank_sel = 1'b0, carrier_lost = 1'b0;
  logic [9:0] vid_out;
  logic       hblank, vblank, field, locked;

  exp_t exp_q[$];
  ctl_t ctl_q[$];
  int   n_chk = 0, n_fail = 0, widx = 0, cl_from = -1, cl_to = -1;
  logic tb_h1 = 0, tb_v = 0, tb_f = 0;
  logic lm_lk = 0, lm_seen = 0, lm_hs = 0;
  int   lm_idle = 0, lm_gap = 0, lm_span = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  vid_trs_flags #(.TIMEOUT(TO)) u_vid_trs_flags (
    .clk(clk), .rst(rst), .vid_in(vid_in), .hblank_sel(hblank_sel),
    .carrier_lost(carrier_lost), .vid_out(vid_out), .hblank(hblank),
    .vblank(vblank), .field(field), .locked(locked)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Driver: applies one word for the coming edge and records expectations
  task automatic push(input logic [9:0] w, input logic h0, input logic is_flag);
    ctl_t c;
    exp_t e;
    logic cl;
    cl = (widx >= cl_from) && (widx < cl_to);
    vid_in = w;
    carrier_lost = cl;
    if (is_flag) begin tb_h1 = w[6]; tb_v = w[7]; tb_f = w[8]; end
    // Lock model (R7, R8)
    if (cl) begin
      lm_lk = 0; lm_seen = 0; lm_hs = 0; lm_idle = 0; lm_gap = 0;
    end else begin
      if (is_flag) lm_idle = 0;
      else if (lm_idle == TO - 1) begin lm_lk = 0; lm_seen = 0; lm_hs = 0; end
      else lm_idle++;
      if (is_flag && w[6]) begin
        if (lm_seen) begin
          lm_lk = lm_hs && (lm_gap + 1 == lm_span);
          lm_span = lm_gap + 1;
          lm_hs = 1;
        end
        lm_gap = 0;
        lm_seen = 1;
      end else if (lm_gap < GAP_MAX) lm_gap++;
    end
    e = '{w: w, h0: h0, h1: tb_h1, v: tb_v, f: tb_f};
    c = '{cl: cl, hm: hblank_sel, lk: lm_lk};
    exp_q.push_back(e);
    ctl_q.push_back(c);
    widx++;
    @(negedge clk);
  endtask

  task automatic send_line(input logic v, input logic f, input int act);
    push(10'h3FF, 1, 0); push(10'h000, 1, 0); push(10'h000, 1, 0);
    push({1'b1, f, v, 1'b1, 6'b0}, 1, 1);
    for (int i = 0; i < HB; i++) push(BLANK, 1, 0);
    push(10'h3FF, 1, 0); push(10'h000, 1, 0); push(10'h000, 1, 0);
    push({1'b1, f, v, 1'b0, 6'b0}, 1, 1);
    for (int i = 0; i < act; i++) push(10'h080 + 10'(i * 3), 0, 0);
  endtask

  task automatic send_idle(input int n);
    for (int i = 0; i < n; i++) push(BLANK, 0, 0);
  endtask

  // Monitor: compares outputs with the scoreboard, one edge at a time
  initial begin
    int k = 0;
    forever begin
      @(posedge clk);
      #2;
      if (ctl_q.size() > 0) begin
        ctl_t c;
        exp_t e;
        c = ctl_q.pop_front();
        e = '{w: BLANK, h0: 0, h1: 0, v: 0, f: 0};
        if (k >= 3) e = exp_q.pop_front();
        if (c.cl) begin
          chk("R6", "muted vid_out", 32'(vid_out), 32'(BLANK));
          chk("R6", "muted flags", {hblank, vblank, field}, 3'b000);
        end else begin
          chk("R2", "vid_out", 32'(vid_out), 32'(e.w));
          chk(c.hm ? "R4" : "R3", "hblank", 32'(hblank), 32'(c.hm ? e.h1 : e.h0));
          chk("R5", "vblank/field", {vblank, field}, {e.v, e.f});
        end
        chk(c.lk ? "R7" : "R8", "locked", 32'(locked), 32'(c.lk));
        k++;
      end
    end
  end

  // Watchdog
  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R1", "reset vid_out", 32'(vid_out), 32'(BLANK));
    chk("R1", "reset flags", {hblank, vblank, field, locked}, 4'b0000);
    rst = 0;
    // Mode 0, vertical blanking then active lines, lock after third EAV
    for (int i = 0; i < 3; i++) send_line(1, 0, ACT);
    for (int i = 0; i < 2; i++) send_line(0, 0, ACT);
    // Carrier loss across the start-of-active sequence
    cl_from = widx + 8; cl_to = widx + 20;
    send_line(0, 0, ACT);
    for (int i = 0; i < 3; i++) send_line(0, 0, ACT);
    // Mode 1 with varied V and F
    hblank_sel = 1;
    for (int i = 0; i < 3; i++) send_line(0, 1, ACT);
    send_line(1, 1, ACT);
    send_line(1, 0, ACT);
    cl_from = widx + 2; cl_to = widx + 6;
    send_line(0, 0, ACT);
    send_line(0, 0, ACT);
    // Spacing mismatch then recovery
    send_line(0, 1, ACT + 2);
    for (int i = 0; i < 3; i++) send_line(0, 1, ACT);
    // Timeout with no sequences
    send_idle(TO + 16);
    for (int i = 0; i < 3; i++) send_line(1, 0, ACT);
    // Back to mode 0, switched within the active region
    hblank_sel = 0;
    for (int i = 0; i < 2; i++) send_line(0, 0, ACT);
    send_idle(4);
    wait (ctl_q.size() == 0);
    @(negedge clk);
    finish_run();
  end
endmodule